// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Receiver

This block is the device side of a host-to-device Ultra DMA burst. When the command logic asks for data, it raises the DMA request and waits until the host acknowledges and has withdrawn its stop request. After a short, fixed number of cycles it signals that it is ready to receive. The host strobe line is sampled in the system clock domain, and every transition of it, rising or falling, delivers one 16-bit word. Each word goes into a write buffer that can be inferred as block RAM, and each word also advances a running CRC.

The device can pause a burst or end it itself. The host can also end a burst with its stop line. When the host releases its acknowledge, the block takes the host's CRC word from the data bus and compares it with its own result. The first burst in a command whose CRC does not match is recorded in a sticky flag together with that burst's index. Both are cleared only when a new command begins.

Top module: `dout_burst_rx`

## Requirements
- R1: After reset, `dmarq` is 0, `ddmardy_n` is 1 and `crc_err` is 0.
- R2: A `burst_go` pulse raises `dmarq` one cycle later. `ddmardy_n` stays high until `dmack_n` is low and `stop` is low. It then falls exactly RDY_DLY+1 clock edges after that condition is first sampled.
- R3: While the burst is receiving, each change of `hstrobe` in either direction stores `dd` at the next buffer address. Addresses restart at 0 on `cmd_start`. The word at `rd_addr` appears on `rd_data` one cycle later.
- R4: The CRC is seeded with 0x4ABA at every `burst_go`. For each received word it shifts in the word MSB first with polynomial x^16+x^12+x^5+1 (0x1021). The current value is shown on `crc_now`.
- R5: `pause_req` has no effect until at least one word of the burst has arrived. After that, `ddmardy_n` goes high while `dmarq` stays high.
- R6: While paused, strobe transitions already in flight (up to two) are still stored and added to the CRC. Dropping `pause_req` lowers `ddmardy_n` again one cycle later.
- R7: `end_req`, once at least one word has arrived, raises `ddmardy_n` at once. `dmarq` then falls exactly TERM_DLY cycles later.
- R8: `stop` going high while the device is ready makes `ddmardy_n` high and `dmarq` low on the next cycle.
- R9: On the rising edge of `dmack_n` after termination, `dd` is compared with the CRC. A mismatch sets `crc_err`, which can rise only at that moment.
- R10: `err_burst` holds the index (counted from 0 after `cmd_start`) of the first mismatching burst. Later mismatches change neither `crc_err` nor `err_burst`. `cmd_start` clears both.
- R11: Once `dmarq` and `ddmardy_n` are both asserted, the device does not raise `ddmardy_n` while `dmarq` stays high until a strobe transition has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | New command: clears error state, burst index and buffer address |
| burst_go | input | 1 | Start a burst (taken when idle) |
| pause_req | input | 1 | Device-side pause request |
| end_req | input | 1 | Device-side termination request |
| dmack_n | input | 1 | Host DMA acknowledge, active low |
| stop | input | 1 | Host stop request |
| hstrobe | input | 1 | Host data strobe |
| dd | input | 16 | Data bus |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | 16 | Buffer read data, one cycle latency |
| dmarq | output | 1 | DMA request |
| ddmardy_n | output | 1 | Device ready, active low |
| crc_now | output | 16 | Running CRC |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| err_burst | output | BW | Index of first mismatching burst |

## Verification
The checker watches the handshake on every cycle. It confirms that readiness is only given while the host acknowledges, that the device never withdraws readiness before it has seen a strobe, that a host stop closes the burst on the next cycle, and that the error flag rises only on an acknowledge release and then keeps its burst index. The bench scenarios are the only place where the data content is checked: buffer contents, the CRC values, and the in-flight words accepted during a pause. The scenarios also check the exact delay counts, the first-error selection across several bursts, and the clearing on a new command.

// File: rtl/dout_pkg.sv
package dout_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_RDY, S_XFER, S_PAUSE, S_TERM, S_END
  } rx_state_t;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'h4ABA;

  // one word, MSB first
  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ d[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/dout_crc16.sv
module dout_crc16
  import dout_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seed,
  input  logic              en,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || seed) crc <= CRC_SEED;
    else if (en)     crc <= crc_step(crc, data);
  end
endmodule

// File: rtl/dout_wbuf.sv
module dout_wbuf #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dout_ctrl.sv
module dout_ctrl
  import dout_pkg::*;
#(
  parameter int unsigned RDY_DLY  = 2,
  parameter int unsigned TERM_DLY = 3,
  parameter int unsigned BW       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              burst_go,
  input  logic              pause_req,
  input  logic              end_req,
  input  logic              dmack_n,
  input  logic              stop,
  input  logic              hstrobe,
  input  logic [WORD_W-1:0] dd,
  input  logic [WORD_W-1:0] crc,
  output logic              cap,
  output logic              seed,
  output logic              dmarq,
  output logic              ddmardy_n,
  output logic              crc_err,
  output logic [BW-1:0]     err_burst
);
  localparam int unsigned MAXD = (RDY_DLY > TERM_DLY) ? RDY_DLY : TERM_DLY;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] RDY_LAST  = CW'(RDY_DLY - 1);
  localparam logic [CW-1:0] TERM_LAST = CW'(TERM_DLY - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic          hs_q, ack_q, have_word;
  logic [BW-1:0] burst_cnt;

  assign cap  = (st == S_XFER || st == S_PAUSE || st == S_TERM) && (hstrobe != hs_q);
  assign seed = (st == S_IDLE) && burst_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      dmarq     <= 1'b0;
      ddmardy_n <= 1'b1;
      hs_q      <= 1'b1;
      ack_q     <= 1'b1;
      have_word <= 1'b0;
      crc_err   <= 1'b0;
      err_burst <= '0;
      burst_cnt <= '0;
    end else begin
      hs_q  <= hstrobe;
      ack_q <= dmack_n;
      if (cap) have_word <= 1'b1;
      case (st)
        S_IDLE: if (burst_go) begin
          dmarq     <= 1'b1;
          have_word <= 1'b0;
          st        <= S_ACK;
        end
        S_ACK: if (!dmack_n && !stop) begin
          cnt <= '0;
          st  <= S_RDY;
        end
        S_RDY: begin
          if (cnt == RDY_LAST) begin
            ddmardy_n <= 1'b0;
            st        <= S_XFER;
          end else cnt <= cnt + 1'b1;
        end
        S_XFER: begin
          if (stop) begin
            ddmardy_n <= 1'b1;
            dmarq     <= 1'b0;
            st        <= S_END;
          end else if (end_req && have_word) begin
            ddmardy_n <= 1'b1;
            cnt       <= '0;
            st        <= S_TERM;
          end else if (pause_req && have_word) begin
            ddmardy_n <= 1'b1;
            st        <= S_PAUSE;
          end
        end
        S_PAUSE: begin
          if (stop) begin
            dmarq <= 1'b0;
            st    <= S_END;
          end else if (end_req) begin
            cnt <= '0;
            st  <= S_TERM;
          end else if (!pause_req) begin
            ddmardy_n <= 1'b0;
            st        <= S_XFER;
          end
        end
        S_TERM: begin
          if (cnt == TERM_LAST) begin
            dmarq <= 1'b0;
            st    <= S_END;
          end else cnt <= cnt + 1'b1;
        end
        S_END: if (dmack_n && !ack_q) begin
          burst_cnt <= burst_cnt + 1'b1;
          if (dd != crc && !crc_err) begin
            crc_err   <= 1'b1;
            err_burst <= burst_cnt;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (cmd_start) begin
        crc_err   <= 1'b0;
        err_burst <= '0;
        burst_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/dout_burst_rx.sv
module dout_burst_rx
  import dout_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned BW       = 4,
  parameter int unsigned RDY_DLY  = 2,
  parameter int unsigned TERM_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              burst_go,
  input  logic              pause_req,
  input  logic              end_req,
  input  logic              dmack_n,
  input  logic              stop,
  input  logic              hstrobe,
  input  logic [WORD_W-1:0] dd,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              dmarq,
  output logic              ddmardy_n,
  output logic [WORD_W-1:0] crc_now,
  output logic              crc_err,
  output logic [BW-1:0]     err_burst
);
  logic          cap, seed;
  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (rst || cmd_start) wr_ptr <= '0;
    else if (cap)         wr_ptr <= wr_ptr + 1'b1;
  end

  dout_ctrl #(.RDY_DLY(RDY_DLY), .TERM_DLY(TERM_DLY), .BW(BW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .burst_go(burst_go),
    .pause_req(pause_req), .end_req(end_req), .dmack_n(dmack_n), .stop(stop),
    .hstrobe(hstrobe), .dd(dd), .crc(crc_now), .cap(cap), .seed(seed),
    .dmarq(dmarq), .ddmardy_n(ddmardy_n), .crc_err(crc_err), .err_burst(err_burst)
  );

  dout_crc16 u_crc (
    .clk(clk), .rst(rst), .seed(seed), .en(cap), .data(dd), .crc(crc_now)
  );

  dout_wbuf #(.DW(WORD_W), .AW(AW)) u_buf (
    .clk(clk), .we(cap), .waddr(wr_ptr), .wdata(dd),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/dout_burst_rx_chk.sv
module dout_burst_rx_chk #(
  parameter int unsigned BW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_start,
  input logic          dmack_n,
  input logic          stop,
  input logic          hstrobe,
  input logic          dmarq,
  input logic          ddmardy_n,
  input logic          crc_err,
  input logic [BW-1:0] err_burst
);
  logic hs_q, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b1;
      seen <= 1'b0;
    end else begin
      hs_q <= hstrobe;
      if (!dmarq)                      seen <= 1'b0;
      else if (hstrobe != hs_q)        seen <= 1'b1;
    end
  end

  // R2
  ready_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ddmardy_n) |-> (!dmack_n && dmarq));

  // R11
  no_early_withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ddmardy_n) && dmarq) |-> seen);

  // R8
  host_stop_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !ddmardy_n && dmarq) |=> (ddmardy_n && !dmarq));

  // R9
  err_on_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err) |-> ($past(dmack_n) && !dmarq));

  // R10
  first_err_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !cmd_start) |=> (crc_err && $stable(err_burst)));
endmodule

bind dout_burst_rx dout_burst_rx_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .cmd_start(cmd_start), .dmack_n(dmack_n), .stop(stop),
  .hstrobe(hstrobe), .dmarq(dmarq), .ddmardy_n(ddmardy_n),
  .crc_err(crc_err), .err_burst(err_burst)
);

// File: tb/dout_burst_rx_test.sv
module dout_burst_rx_test;
  localparam int AW = 6, BW = 4, RDY_DLY = 2, TERM_DLY = 3;

  logic clk = 0, rst = 1;
  logic cmd_start = 0, burst_go = 0, pause_req = 0, end_req = 0;
  logic dmack_n = 1, stop = 1, hstrobe = 1;
  logic [15:0] dd = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data, crc_now;
  logic dmarq, ddmardy_n, crc_err;
  logic [BW-1:0] err_burst;

  int errors = 0, checks = 0;
  logic [15:0] exp_crc;
  logic [15:0] exp_mem [64];
  int wp = 0;

  always #4 clk = ~clk;

  dout_burst_rx #(.AW(AW), .BW(BW), .RDY_DLY(RDY_DLY), .TERM_DLY(TERM_DLY)) uut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .burst_go(burst_go),
    .pause_req(pause_req), .end_req(end_req), .dmack_n(dmack_n), .stop(stop),
    .hstrobe(hstrobe), .dd(dd), .rd_addr(rd_addr), .rd_data(rd_data),
    .dmarq(dmarq), .ddmardy_n(ddmardy_n), .crc_now(crc_now),
    .crc_err(crc_err), .err_burst(err_burst)
  );

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_burst();
    int k;
    @(negedge clk); burst_go = 1;
    @(negedge clk); burst_go = 0;
    chk(dmarq == 1, "R2 dmarq up", dmarq, 1);
    exp_crc = 16'h4ABA;
    @(negedge clk);
    chk(ddmardy_n == 1, "R2 no ready before ack", ddmardy_n, 1);
    dmack_n = 0; stop = 0;
    for (k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (!ddmardy_n) break;
    end
    chk(k == RDY_DLY + 1, "R2 ready delay", k, RDY_DLY + 1);
  endtask

  task automatic send_word(input logic [15:0] w);
    dd = w; hstrobe = ~hstrobe;
    exp_mem[wp % 64] = w; wp++;
    exp_crc = model_crc(exp_crc, w);
    @(negedge clk);
  endtask

  task automatic host_end(input logic [15:0] cv);
    stop = 1;
    @(negedge clk);
    chk(ddmardy_n == 1 && dmarq == 0, "R8 host stop", {ddmardy_n, dmarq}, 2);
    dd = cv; dmack_n = 1;
    @(negedge clk);
  endtask

  task automatic read_chk(input int a, input string tag);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(rd_data == exp_mem[a], tag, rd_data, exp_mem[a]);
  endtask

  task automatic t_reset();
    chk(dmarq == 0, "R1 dmarq", dmarq, 0);
    chk(ddmardy_n == 1, "R1 ddmardy_n", ddmardy_n, 1);
    chk(crc_err == 0, "R1 crc_err", crc_err, 0);
  endtask

  task automatic t_plain();
    start_burst();
    send_word(16'h1234); send_word(16'hFFFF); send_word(16'h0000); send_word(16'hA5C3);
    chk(crc_now == exp_crc, "R4 crc four words", crc_now, exp_crc);
    host_end(exp_crc);
    chk(crc_err == 0, "R9 good crc no error", crc_err, 0);
    for (int a = 0; a < 4; a++) read_chk(a, "R3 buffer plain");
  endtask

  task automatic t_pause_devend();
    start_burst();
    pause_req = 1;
    repeat (2) @(negedge clk);
    chk(ddmardy_n == 0, "R5 pause ignored before word", ddmardy_n, 0);
    send_word(16'h0F0F);
    @(negedge clk);
    chk(ddmardy_n == 1 && dmarq == 1, "R5 paused", {ddmardy_n, dmarq}, 3);
    send_word(16'hBEEF); send_word(16'h8001);
    chk(crc_now == exp_crc, "R6 in-flight words in crc", crc_now, exp_crc);
    pause_req = 0;
    @(negedge clk);
    chk(ddmardy_n == 0, "R6 resume", ddmardy_n, 0);
    send_word(16'h7E7E);
    end_req = 1;
    @(negedge clk);
    end_req = 0;
    chk(ddmardy_n == 1 && dmarq == 1, "R7 ready drop first", {ddmardy_n, dmarq}, 3);
    repeat (TERM_DLY - 1) @(negedge clk);
    chk(dmarq == 1, "R7 dmarq held", dmarq, 1);
    @(negedge clk);
    chk(dmarq == 0, "R7 dmarq drop", dmarq, 0);
    stop = 1; dd = exp_crc ^ 16'h0001; dmack_n = 1;
    @(negedge clk);
    chk(crc_err == 1, "R9 mismatch flagged", crc_err, 1);
    chk(err_burst == 1, "R10 first burst index", err_burst, 1);
    for (int a = 4; a < 8; a++) read_chk(a, "R3 R6 buffer pause");
  endtask

  task automatic t_second_err();
    start_burst();
    send_word(16'h5555);
    host_end(16'h0000);
    chk(crc_err == 1 && err_burst == 1, "R10 later error ignored", err_burst, 1);
    @(negedge clk); cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    chk(crc_err == 0 && err_burst == 0, "R10 cleared by new command", {crc_err, err_burst}, 0);
  endtask

  task automatic t_new_cmd();
    wp = 0;
    start_burst();
    send_word(16'hC001); send_word(16'h00FF);
    chk(crc_now == exp_crc, "R4 reseeded crc", crc_now, exp_crc);
    host_end(exp_crc ^ 16'h8000);
    chk(crc_err == 1 && err_burst == 0, "R10 index restarts", {crc_err, err_burst}, 16);
    read_chk(0, "R3 address restart");
    read_chk(1, "R3 address restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_pause_devend();
    t_second_err();
    t_new_cmd();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule